// File: doc/BRIEF.md
# Transmit Feed-Forward Equalizer Tap Controller

This block shapes the digital drive level of a serial transmit lane. Every clock carries one bit. Each bit is turned into a signed amplitude word by a four-tap filter. The taps are a pre-cursor on the following bit, a main cursor on the bit itself, and two post-cursors on the one and two preceding bits. Logic 1 counts as +1 and logic 0 counts as -1.

The main-cursor weight is never programmed. It is derived as the full scale (31) minus the magnitudes of the other three taps, so the absolute weights always total full scale. When the three programmed magnitudes together exceed full scale, the main cursor clamps at zero and a sticky error flag is raised.

A mode input picks the source of the three programmed taps:

- **Protocol mode:** the taps come from an eight-entry preset table, and the second post-cursor is held at zero. An override input swaps the preset table for the register values, and the second post-cursor stays at zero.
- **Generic mode:** all three taps, including the second post-cursor, come from the register inputs.

Tap controls are captured as a complete set once per symbol, so no single output sample mixes old and new weights.

Top module: `tx_ffe_ctrl`

## Requirements
- R1: The output sample for bit n is Cpre·d(n+1) + Cmain·d(n) + Cpost1·d(n−1) + Cpost2·d(n−2). It is registered at the second rising edge after bit n is sampled.
- R2: Symbols map as logic 1 → +1 and logic 0 → −1. While reset is high, the delay line holds all −1, the output is 0, the error flag is 0, the main cursor is 31 and the other taps are 0. The first sample after reset is therefore −31.
- R3: When the three programmed magnitudes sum to 31 or less, the main cursor equals 31 minus that sum. The main cursor is always positive.
- R4: When the sum exceeds 31, the main cursor becomes 0 and `norm_err` rises. `norm_err` stays high until reset, even after the taps return to legal values.
- R5: In protocol mode without override, preset index i gives a pre-cursor magnitude of (i mod 4)·2 and a post-cursor-1 magnitude of (i div 2)·3. Both of these taps are negative, and post-cursor 2 is 0.
- R6: In protocol mode with `ovr_en`=1, the pre-cursor and post-cursor-1 come from the register inputs, and post-cursor 2 is still forced to 0 whatever its register holds.
- R7: In generic mode, all three taps come from the register inputs, and post-cursor 2 contributes to the output.
- R8: Each programmed tap has a sign input where 1 means negative and 0 means positive.
- R9: The tap controls present at rising edge k are applied in full to the sample registered at edge k+1, and never in part.
- R10: While `norm_err` is 0, every sample after the first post-reset edge is odd and lies within −31..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit, one per clock |
| mode_generic | input | 1 | 1: register taps with post-cursor 2; 0: protocol mode |
| ovr_en | input | 1 | Protocol mode: use register taps instead of the preset table |
| preset_idx | input | 3 | Preset table index |
| pre_mag | input | 5 | Pre-cursor magnitude |
| pre_neg | input | 1 | Pre-cursor sign (1 = negative) |
| post1_mag | input | 5 | Post-cursor 1 magnitude |
| post1_neg | input | 1 | Post-cursor 1 sign |
| post2_mag | input | 5 | Post-cursor 2 magnitude |
| post2_neg | input | 1 | Post-cursor 2 sign |
| ffe_out | output | 8 | Signed output amplitude |
| norm_err | output | 1 | Sticky normalization overflow flag |

## Verification
A wrong symbol in the delay line shows up at `ffe_out` one to four samples later. It appears as a sample whose value is off by twice a single tap weight. A wrong captured tap set, such as a leaked post-cursor 2 in protocol mode or a wrong main cursor, corrupts the very next sample. It usually also breaks the odd-and-bounded property while no overflow is flagged. A lost sticky error shows up on the first sample after the taps return to legal values. A reference model compares both outputs on every clock, across random bits in each mode, preset and override, so such faults are caught within a few cycles.

// File: rtl/tx_ffe_pkg.sv
package tx_ffe_pkg;
  localparam int TAP_W      = 5;
  localparam int PRESET_W   = 3;
  localparam int OUT_W      = 8;
  localparam int NUM_TAPS   = 4;
  localparam int FULL_SCALE = (1 << TAP_W) - 1;
  localparam int SUM_W      = TAP_W + 2;

  typedef struct packed {
    logic [TAP_W-1:0] mag;
    logic             neg;
  } tap_t;

  typedef struct packed {
    tap_t pre;
    tap_t post1;
    tap_t post2;
  } side_taps_t;

  // Preset table: pre = (i mod 4)*2, post1 = (i div 2)*3, both negative.
  function automatic side_taps_t preset_entry(input logic [PRESET_W-1:0] idx);
    side_taps_t e;
    e.pre.mag   = TAP_W'(2 * int'(idx[1:0]));
    e.pre.neg   = 1'b1;
    e.post1.mag = TAP_W'(3 * int'(idx[2:1]));
    e.post1.neg = 1'b1;
    e.post2     = '0;
    return e;
  endfunction
endpackage

// File: rtl/tx_ffe_tap_sel.sv
module tx_ffe_tap_sel
  import tx_ffe_pkg::*;
(
  input  logic                mode_generic,
  input  logic                ovr_en,
  input  logic [PRESET_W-1:0] preset_idx,
  input  side_taps_t          reg_taps,
  output side_taps_t          sel_taps
);
  side_taps_t rom [1 << PRESET_W];

  for (genvar i = 0; i < (1 << PRESET_W); i++) begin : g_rom
    assign rom[i] = preset_entry(PRESET_W'(i));
  end

  always_comb begin
    if (mode_generic) begin
      sel_taps = reg_taps;
    end else if (ovr_en) begin
      sel_taps       = reg_taps;
      sel_taps.post2 = '0;   // R6: second post-cursor unused in protocol mode
    end else begin
      sel_taps = rom[preset_idx];   // R5
    end
  end
endmodule

// File: rtl/tx_ffe_norm.sv
module tx_ffe_norm
  import tx_ffe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  side_taps_t       sel_taps,
  output side_taps_t       taps_q,
  output logic [TAP_W-1:0] main_q,
  output logic             err_q
);
  logic [SUM_W-1:0] side_sum;
  logic             over;
  logic [TAP_W-1:0] main_d;

  always_comb begin
    side_sum = SUM_W'(sel_taps.pre.mag) + SUM_W'(sel_taps.post1.mag)
             + SUM_W'(sel_taps.post2.mag);
    over     = side_sum > SUM_W'(FULL_SCALE);
    main_d   = over ? '0 : TAP_W'(SUM_W'(FULL_SCALE) - side_sum);
  end

  // One register stage captures the whole tap set at a symbol boundary (R9).
  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q <= '0;
      main_q <= TAP_W'(FULL_SCALE);
      err_q  <= 1'b0;
    end else begin
      taps_q <= sel_taps;
      main_q <= main_d;
      err_q  <= err_q | over;
    end
  end
endmodule

// File: rtl/tx_ffe_delay.sv
module tx_ffe_delay #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [DEPTH-1:0] sym_q
);
  // sym_q[0] newest; logic 0 stands for a -1 symbol.
  always_ff @(posedge clk) begin
    if (rst) sym_q <= '0;
    else     sym_q <= {sym_q[DEPTH-2:0], bit_in};
  end
endmodule

// File: rtl/tx_ffe_mac.sv
module tx_ffe_mac
  import tx_ffe_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_TAPS-1:0]     sym,
  input  logic [TAP_W-1:0]        mag [NUM_TAPS],
  input  logic [NUM_TAPS-1:0]     neg,
  output logic signed [OUT_W-1:0] out_q
);
  logic signed [OUT_W-1:0] term [NUM_TAPS];
  logic signed [OUT_W-1:0] acc;

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_term
    logic signed [OUT_W-1:0] m;
    assign m       = signed'({{(OUT_W-TAP_W){1'b0}}, mag[t]});
    assign term[t] = (sym[t] ^ neg[t]) ? m : -m;
  end

  always_comb begin
    acc = '0;
    for (int t = 0; t < NUM_TAPS; t++) acc = acc + term[t];
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= acc;
  end
endmodule

// File: rtl/tx_ffe_ctrl.sv
module tx_ffe_ctrl
  import tx_ffe_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_in,
  input  logic                    mode_generic,
  input  logic                    ovr_en,
  input  logic [PRESET_W-1:0]     preset_idx,
  input  logic [TAP_W-1:0]        pre_mag,
  input  logic                    pre_neg,
  input  logic [TAP_W-1:0]        post1_mag,
  input  logic                    post1_neg,
  input  logic [TAP_W-1:0]        post2_mag,
  input  logic                    post2_neg,
  output logic signed [OUT_W-1:0] ffe_out,
  output logic                    norm_err
);
  side_taps_t       reg_taps, sel_taps, taps_q;
  logic [TAP_W-1:0] main_q;
  logic [NUM_TAPS-1:0] sym_q;
  logic [TAP_W-1:0] mag_v [NUM_TAPS];
  logic [NUM_TAPS-1:0] neg_v;
  logic [TAP_W-1:0] c2_mag_q;

  assign reg_taps.pre   = '{mag: pre_mag,   neg: pre_neg};
  assign reg_taps.post1 = '{mag: post1_mag, neg: post1_neg};
  assign reg_taps.post2 = '{mag: post2_mag, neg: post2_neg};

  tx_ffe_tap_sel sel_i (
    .mode_generic(mode_generic), .ovr_en(ovr_en), .preset_idx(preset_idx),
    .reg_taps(reg_taps), .sel_taps(sel_taps)
  );

  tx_ffe_norm norm_i (
    .clk(clk), .rst(rst), .sel_taps(sel_taps),
    .taps_q(taps_q), .main_q(main_q), .err_q(norm_err)
  );

  tx_ffe_delay #(.DEPTH(NUM_TAPS)) dly_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .sym_q(sym_q)
  );

  // Tap order matches sym_q: next, current, previous, two back.
  assign mag_v[0] = taps_q.pre.mag;
  assign mag_v[1] = main_q;
  assign mag_v[2] = taps_q.post1.mag;
  assign mag_v[3] = taps_q.post2.mag;
  assign neg_v    = {taps_q.post2.neg, taps_q.post1.neg, 1'b0, taps_q.pre.neg};
  assign c2_mag_q = taps_q.post2.mag;

  tx_ffe_mac mac_i (
    .clk(clk), .rst(rst), .sym(sym_q), .mag(mag_v), .neg(neg_v), .out_q(ffe_out)
  );
endmodule

// File: rtl/tx_ffe_ctrl_chk.sv
module tx_ffe_ctrl_chk
  import tx_ffe_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    mode_generic,
  input logic signed [OUT_W-1:0] ffe_out,
  input logic                    norm_err,
  input logic [TAP_W-1:0]        c2_mag_q,
  input logic [TAP_W-1:0]        c0_mag_q
);
  a_r2_reset_out: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ffe_out == '0);

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(norm_err) |-> norm_err);

  a_r4_main_clamped: assert property (@(posedge clk) disable iff (rst)
    $rose(norm_err) |-> c0_mag_q == '0);

  a_r5_std_post2_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_generic) |-> c2_mag_q == '0);

  a_r10_odd_bounded: assert property (@(posedge clk) disable iff (rst)
    (!norm_err && !$past(rst)) |->
      (ffe_out[0] && ffe_out <= OUT_W'(FULL_SCALE) && ffe_out >= -OUT_W'(FULL_SCALE)));
endmodule

bind tx_ffe_ctrl tx_ffe_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .mode_generic(mode_generic), .ffe_out(ffe_out),
  .norm_err(norm_err), .c2_mag_q(c2_mag_q), .c0_mag_q(main_q)
);

// File: tb/tx_ffe_ctrl_tb_top.sv
`timescale 1ns/1ps
module tx_ffe_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0, mode_generic = 1'b0, ovr_en = 1'b0;
  logic [2:0] preset_idx = '0;
  logic [4:0] pre_mag = '0, post1_mag = '0, post2_mag = '0;
  logic pre_neg = 1'b0, post1_neg = 1'b0, post2_neg = 1'b0;
  logic signed [7:0] ffe_out;
  logic norm_err;

  int checks = 0, errors = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  tx_ffe_ctrl dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .mode_generic(mode_generic),
    .ovr_en(ovr_en), .preset_idx(preset_idx), .pre_mag(pre_mag), .pre_neg(pre_neg),
    .post1_mag(post1_mag), .post1_neg(post1_neg), .post2_mag(post2_mag),
    .post2_neg(post2_neg), .ffe_out(ffe_out), .norm_err(norm_err)
  );

  // Behavioural reference model
  int hist[$];
  int m_pre, m_p1, m_p2, m_c0;
  int s_pre, s_p1, s_p2;
  int exp_out = 0;
  bit exp_err = 0;

  function automatic int sg(input logic n);
    return n ? -1 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist = '{-1, -1, -1, -1};
      m_pre = 0; m_p1 = 0; m_p2 = 0; m_c0 = 31;
      s_pre = 1; s_p1 = 1; s_p2 = 1;
      exp_out = 0; exp_err = 0;
    end else begin
      int s;
      exp_out = s_pre*m_pre*hist[0] + m_c0*hist[1] + s_p1*m_p1*hist[2] + s_p2*m_p2*hist[3];
      if (mode_generic) begin            // R7
        m_pre = pre_mag; s_pre = sg(pre_neg);
        m_p1 = post1_mag; s_p1 = sg(post1_neg);
        m_p2 = post2_mag; s_p2 = sg(post2_neg);
      end else if (ovr_en) begin         // R6
        m_pre = pre_mag; s_pre = sg(pre_neg);
        m_p1 = post1_mag; s_p1 = sg(post1_neg);
        m_p2 = 0; s_p2 = 1;
      end else begin                     // R5
        m_pre = (preset_idx % 4) * 2; s_pre = -1;
        m_p1 = (preset_idx / 2) * 3; s_p1 = -1;
        m_p2 = 0; s_p2 = 1;
      end
      s = m_pre + m_p1 + m_p2;
      if (s > 31) begin m_c0 = 0; exp_err = 1; end   // R4
      else m_c0 = 31 - s;                            // R3
      hist.push_front(bit_in ? 1 : -1);
      void'(hist.pop_back());
    end
  end

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_int({cur_req, " ffe_out"}, int'(ffe_out), exp_out);
    check_int({cur_req, " norm_err"}, int'(norm_err), int'(exp_err));
  endtask

  task automatic set_regs(input int a, input bit an, input int b, input bit bn,
                          input int c, input bit cn);
    pre_mag = 5'(a); pre_neg = an; post1_mag = 5'(b); post1_neg = bn;
    post2_mag = 5'(c); post2_neg = cn;
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      bit_in = 1'($urandom_range(0, 1));
    end
  endtask

  bit done = 0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2: reset state, then first sample -31
    cur_req = "R2";
    repeat (3) step();
    check_int("R2 reset out", int'(ffe_out), 0);
    rst = 1'b0;
    step();
    check_int("R2 first sample", int'(ffe_out), -31);

    // R1/R7/R8: generic mode with every tap, alternating and runs of bits
    cur_req = "R1/R7/R8";
    mode_generic = 1'b1;
    set_regs(3, 1'b1, 6, 1'b1, 4, 1'b0);
    for (int i = 0; i < 40; i++) begin step(); bit_in = 1'(i % 2); end
    for (int i = 0; i < 40; i++) begin step(); bit_in = 1'((i / 5) % 2); end
    set_regs(0, 1'b0, 0, 1'b0, 9, 1'b1);   // post-cursor 2 alone shapes the output (R7)
    run_random(60);

    // R3/R9: tap changes every symbol, applied whole
    cur_req = "R3/R9";
    for (int i = 0; i < 200; i++) begin
      step();
      set_regs($urandom_range(0, 10), 1'($urandom_range(0, 1)), $urandom_range(0, 10),
               1'($urandom_range(0, 1)), $urandom_range(0, 10), 1'($urandom_range(0, 1)));
      bit_in = 1'($urandom_range(0, 1));
    end

    // R5: preset sweep in protocol mode, post2 registers ignored
    cur_req = "R5";
    mode_generic = 1'b0; ovr_en = 1'b0;
    set_regs(25, 1'b0, 25, 1'b0, 25, 1'b0);
    for (int p = 0; p < 8; p++) begin preset_idx = 3'(p); run_random(30); end

    // R6: override, post2 still zero
    cur_req = "R6";
    ovr_en = 1'b1;
    set_regs(5, 1'b1, 8, 1'b0, 20, 1'b1);
    run_random(60);

    // R10: long legal run
    cur_req = "R10";
    mode_generic = 1'b1;
    set_regs(7, 1'b1, 7, 1'b1, 7, 1'b1);
    run_random(100);

    // R4: overflow clamps main cursor and latches the error
    cur_req = "R4";
    set_regs(20, 1'b1, 10, 1'b0, 5, 1'b1);
    run_random(20);
    check_int("R4 err set", int'(norm_err), 1);
    set_regs(2, 1'b0, 2, 1'b0, 2, 1'b0);
    run_random(20);
    check_int("R4 err sticky", int'(norm_err), 1);
    rst = 1'b1; step(); step();
    check_int("R4 err cleared by reset", int'(norm_err), 0);
    rst = 1'b0;
    cur_req = "R1/R3/R9";
    run_random(100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule